// File: doc/BRIEF.md
# Power-Down Clock and Wake Controller

This block decides what happens to the interface clocks of a line-interface transceiver while it is powered down. A configuration bit selects whether the clocks keep running through power down or stop. When they stop, the serial bus outputs are held at fixed idle levels: both data lines high and both clock outputs low. The block restarts the clocks when the line becomes active or when software requests a local wake-up. It also holds a sticky level-detect status bit for software and sets pin directions when the transceiver is disabled.

The controller is a four-state machine. `RUN` means the clocks are enabled. `STOP_PEND` means a stop has been requested and the block is waiting for the clock's low phase. `STOPPED` means the clocks are off and the bus is parked. `WAKE_PEND` means a restart has been requested and the block is waiting for the clock's low phase. The transitions are as follows:
- RUN→STOP_PEND happens on a power-down entry pulse when clock stop is selected.
- STOP_PEND→STOPPED happens when the low phase is seen.
- STOP_PEND→RUN (cancel) happens when clock stop is deselected or a wake arrives.
- STOPPED→WAKE_PEND happens on a line wake, a local wake or deselection of clock stop.
- WAKE_PEND→RUN happens when the low phase is seen.

A second small machine tracks the local wake-up sequence through `IDLE`, `SET` and `ARMED`. It moves IDLE→SET when the power-up bit is 1, and SET→ARMED when that bit returns to 0. From ARMED, a write of the wake command fires the wake and returns to IDLE. If the bit is set again while ARMED, the machine goes back to SET.

Top module: `pd_clock_wake`

## Requirements
- R1: After synchronous reset the clock enable is 1, the parking outputs are 0, and the level-detect status and interrupt are 0.
- R2: When the clock-stop select is 0, a power-down entry pulse leaves the clock enable at 1.
- R3: When the clock-stop select is 1, a power-down entry pulse stops the clocks. The clock enable falls only in the cycle after `clk_phase_low` was sampled 1, and stays 1 while the phase input is 0.
- R4: While the clock enable is 0, `data_hold_high` and `clk_hold_low` are both 1. While the clock enable is 1, both are 0.
- R5: With the clocks stopped, the transceiver enabled and the level-detect mode at 0, a level-detect pulse restarts the clocks at the next low phase.
- R6: With the level-detect mode at 1, a level-detect pulse while the clocks are stopped leaves them stopped and sets `ld_status`. `irq` follows `ld_status` when `irq_enable` is 1.
- R7: `ld_status` stays set until a cycle with `ld_clear` at 1 clears it. While `irq_enable` is 0, `irq` is 0.
- R8: A local wake needs three steps: the power-up bit set to 1, then returned to 0, then a command write with code 4'h0. Together these restart stopped clocks. A command write without that preceding sequence, or with any other code, does not restart them.
- R9: Clearing the clock-stop select while the clocks are stopped restarts them at the next low phase.
- R10: When the transceiver disable is 1, level-detect pulses neither restart the clocks nor set `ld_status`, and `dclk_dir_in` and `fsync_dir_in` are 1. Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_clk_stop_sel | input | 1 | 1: stop clocks in power down |
| cfg_ld_irq_mode | input | 1 | 1: line activity only raises status |
| cfg_xcvr_disable | input | 1 | 1: transceiver and level detector disabled |
| pd_enter | input | 1 | Power-down entry pulse |
| clk_phase_low | input | 1 | Generated clock is in its low phase |
| ld_pulse | input | 1 | Level-detect pulse from the receiver |
| pwr_up_bit | input | 1 | Software power-up request bit |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_code | input | 4 | Command code written |
| ld_clear | input | 1 | Write-one-to-clear of level-detect status |
| irq_enable | input | 1 | Level-detect interrupt enable |
| clk_en | output | 1 | Interface clock enable |
| data_hold_high | output | 1 | Hold both data lines high |
| clk_hold_low | output | 1 | Hold both clock outputs low |
| dclk_dir_in | output | 1 | Data clock pin acts as input |
| fsync_dir_in | output | 1 | Frame sync pin acts as input |
| ld_status | output | 1 | Sticky level-detect status |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds the clock phase high for several cycles after a stop or wake request. A design that switches the enable without waiting for the low phase would change `clk_en` early and cut a clock pulse short. It sends wake commands with no power-up pulse first, with the bit only set and not cleared, and with a wrong code. A design that accepted any of these would wake spuriously. It sends level-detect pulses in interrupt mode and while disabled. A design that ignored the mode or disable would restart the clocks or set status where it must not.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_STOP_PEND = 2'd1,
        ST_STOPPED   = 2'd2,
        ST_WAKE_PEND = 2'd3
    } pd_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SET   = 2'd1,
        SQ_ARMED = 2'd2
    } wake_seq_t;
endpackage

// File: rtl/pdw_local_wake.sv
module pdw_local_wake #(
    parameter int          CMD_W    = 4,
    parameter logic [CMD_W-1:0] WAKE_CMD = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_up_bit,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             wake_o
);
    import pdw_pkg::*;

    wake_seq_t sq_q, sq_d;

    always_ff @(posedge clk) begin
        if (rst) sq_q <= SQ_IDLE;
        else     sq_q <= sq_d;
    end

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q)
            SQ_IDLE:  if (pwr_up_bit) sq_d = SQ_SET;
            SQ_SET:   if (!pwr_up_bit) sq_d = SQ_ARMED;
            SQ_ARMED: begin
                if (pwr_up_bit) sq_d = SQ_SET;
                else if (cmd_wr && cmd_code == WAKE_CMD) sq_d = SQ_IDLE;
            end
            default:  sq_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        wake_o = (sq_q == SQ_ARMED) && !pwr_up_bit && cmd_wr && (cmd_code == WAKE_CMD);
    end

    // R8: arming is only reached from the set step
    assert_arm_after_set_R8: assert property (@(posedge clk) disable iff (rst)
        (sq_q == SQ_ARMED && $past(sq_q) != SQ_ARMED) |-> $past(sq_q) == SQ_SET);
endmodule

// File: rtl/pdw_ld_status.sv
module pdw_ld_status (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clear_i,
    input  logic irq_enable,
    output logic status_o,
    output logic irq_o
);
    logic st_q;

    always_ff @(posedge clk) begin
        if (rst)          st_q <= 1'b0;
        else if (set_i)   st_q <= 1'b1;
        else if (clear_i) st_q <= 1'b0;
    end

    always_comb begin
        status_o = st_q;
        irq_o    = st_q & irq_enable;
    end

    // R7: status is sticky until a clear
    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (status_o && !clear_i) |=> status_o);
endmodule

// File: rtl/pdw_clk_fsm.sv
module pdw_clk_fsm (
    input  logic clk,
    input  logic rst,
    input  logic pd_enter,
    input  logic stop_sel,
    input  logic phase_low,
    input  logic line_wake,
    input  logic local_wake,
    output logic clk_en,
    output logic stopped,
    output logic park
);
    import pdw_pkg::*;

    pd_state_t st_q, st_d;
    logic      any_wake;

    always_comb any_wake = line_wake | local_wake | !stop_sel;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RUN;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:       if (pd_enter && stop_sel) st_d = ST_STOP_PEND;
            ST_STOP_PEND: begin
                if (any_wake)       st_d = ST_RUN;
                else if (phase_low) st_d = ST_STOPPED;
            end
            ST_STOPPED:   if (any_wake) st_d = ST_WAKE_PEND;
            ST_WAKE_PEND: if (phase_low) st_d = ST_RUN;
            default:      st_d = ST_RUN;
        endcase
    end

    always_comb begin
        clk_en  = 1'b1;
        stopped = 1'b0;
        park    = 1'b0;
        unique case (st_q)
            ST_RUN, ST_STOP_PEND: clk_en = 1'b1;
            ST_STOPPED: begin
                clk_en  = 1'b0;
                stopped = 1'b1;
                park    = 1'b1;
            end
            ST_WAKE_PEND: begin
                clk_en = 1'b0;
                park   = 1'b1;
            end
            default: clk_en = 1'b1;
        endcase
    end

    // R3: the enable only moves after a sampled low phase
    assert_en_low_phase_R3: assert property (@(posedge clk) disable iff (rst)
        (clk_en != $past(clk_en)) |-> $past(phase_low));
    // R2: clocks never stop unless stop is selected
    assert_stop_needs_sel_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> $past(stop_sel));
endmodule

// File: rtl/pd_clock_wake.sv
module pd_clock_wake #(
    parameter int               CMD_W    = 4,
    parameter logic [CMD_W-1:0] WAKE_CMD = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_clk_stop_sel,
    input  logic             cfg_ld_irq_mode,
    input  logic             cfg_xcvr_disable,
    input  logic             pd_enter,
    input  logic             clk_phase_low,
    input  logic             ld_pulse,
    input  logic             pwr_up_bit,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             ld_clear,
    input  logic             irq_enable,
    output logic             clk_en,
    output logic             data_hold_high,
    output logic             clk_hold_low,
    output logic             dclk_dir_in,
    output logic             fsync_dir_in,
    output logic             ld_status,
    output logic             irq
);
    logic ld_valid, line_wake, seq_wake, stopped, park, ld_set;

    always_comb begin
        ld_valid  = ld_pulse & !cfg_xcvr_disable;
        line_wake = ld_valid & !cfg_ld_irq_mode;
    end

    pdw_local_wake #(.CMD_W(CMD_W), .WAKE_CMD(WAKE_CMD)) u_seq (
        .clk(clk), .rst(rst), .pwr_up_bit(pwr_up_bit),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code), .wake_o(seq_wake)
    );

    pdw_clk_fsm u_fsm (
        .clk(clk), .rst(rst), .pd_enter(pd_enter), .stop_sel(cfg_clk_stop_sel),
        .phase_low(clk_phase_low), .line_wake(line_wake), .local_wake(seq_wake),
        .clk_en(clk_en), .stopped(stopped), .park(park)
    );

    always_comb ld_set = ld_valid & cfg_ld_irq_mode & stopped;

    pdw_ld_status u_ld (
        .clk(clk), .rst(rst), .set_i(ld_set), .clear_i(ld_clear),
        .irq_enable(irq_enable), .status_o(ld_status), .irq_o(irq)
    );

    always_comb begin
        data_hold_high = park;
        clk_hold_low   = park;
        dclk_dir_in    = cfg_xcvr_disable;
        fsync_dir_in   = cfg_xcvr_disable;
    end

    // R6: status only rises on a valid detect in interrupt mode
    assert_status_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ld_status) |-> ($past(cfg_ld_irq_mode) && !$past(cfg_xcvr_disable)));
    // R10: a disabled transceiver stays stopped without a local wake
    assert_disabled_stays_R10: assert property (@(posedge clk) disable iff (rst)
        (stopped && cfg_xcvr_disable && cfg_clk_stop_sel && !seq_wake) |=> stopped);
    // R4: parking is released only as the clocks return
    assert_park_release_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(data_hold_high) |-> $rose(clk_en));
endmodule

// File: tb/pd_clock_wake_test.sv
module pd_clock_wake_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_clk_stop_sel = 0, cfg_ld_irq_mode = 0, cfg_xcvr_disable = 0;
    logic pd_enter = 0, clk_phase_low = 0, ld_pulse = 0, pwr_up_bit = 0;
    logic cmd_wr = 0, ld_clear = 0, irq_enable = 0;
    logic [3:0] cmd_code = 4'h0;
    logic clk_en, data_hold_high, clk_hold_low, dclk_dir_in, fsync_dir_in, ld_status, irq;
    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pd_clock_wake uut (
        .clk(clk), .rst(rst), .cfg_clk_stop_sel(cfg_clk_stop_sel),
        .cfg_ld_irq_mode(cfg_ld_irq_mode), .cfg_xcvr_disable(cfg_xcvr_disable),
        .pd_enter(pd_enter), .clk_phase_low(clk_phase_low), .ld_pulse(ld_pulse),
        .pwr_up_bit(pwr_up_bit), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .ld_clear(ld_clear), .irq_enable(irq_enable), .clk_en(clk_en),
        .data_hold_high(data_hold_high), .clk_hold_low(clk_hold_low),
        .dclk_dir_in(dclk_dir_in), .fsync_dir_in(fsync_dir_in),
        .ld_status(ld_status), .irq(irq)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1; cfg_clk_stop_sel = 0; cfg_ld_irq_mode = 0; cfg_xcvr_disable = 0;
        pd_enter = 0; clk_phase_low = 0; ld_pulse = 0; pwr_up_bit = 0;
        cmd_wr = 0; cmd_code = 4'h0; ld_clear = 0; irq_enable = 0;
        step(2); rst = 0; step();
    endtask

    task automatic enter_stop();
        cfg_clk_stop_sel = 1; clk_phase_low = 1; pd_enter = 1; step();
        pd_enter = 0; step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 clk_en", clk_en, 1'b1);
        chk("R1 park", data_hold_high | clk_hold_low, 1'b0);
        chk("R1 status", ld_status | irq, 1'b0);
    endtask

    task automatic t_no_stop();
        do_reset();
        clk_phase_low = 1; pd_enter = 1; step(); pd_enter = 0; step(3);
        chk("R2 clk_en stays", clk_en, 1'b1);
    endtask

    task automatic t_stop_waits();
        do_reset();
        cfg_clk_stop_sel = 1; clk_phase_low = 0; pd_enter = 1; step(); pd_enter = 0;
        step(3);
        chk("R3 waits for low phase", clk_en, 1'b1);
        chk("R4 no park while running", data_hold_high, 1'b0);
        clk_phase_low = 1; step();
        chk("R3 stopped after low phase", clk_en, 1'b0);
        chk("R4 data held high", data_hold_high, 1'b1);
        chk("R4 clocks held low", clk_hold_low, 1'b1);
    endtask

    task automatic t_line_wake();
        do_reset(); enter_stop();
        clk_phase_low = 0; ld_pulse = 1; step(); ld_pulse = 0; step(2);
        chk("R5 waits low phase", clk_en, 1'b0);
        clk_phase_low = 1; step();
        chk("R5 restarted", clk_en, 1'b1);
        chk("R5 no status in mode 0", ld_status, 1'b0);
    endtask

    task automatic t_irq_mode();
        do_reset(); cfg_ld_irq_mode = 1; enter_stop();
        ld_pulse = 1; step(); ld_pulse = 0; step(2);
        chk("R6 stays stopped", clk_en, 1'b0);
        chk("R6 status set", ld_status, 1'b1);
        chk("R7 irq masked", irq, 1'b0);
        irq_enable = 1; step();
        chk("R6 irq raised", irq, 1'b1);
        step(3);
        chk("R7 sticky", ld_status, 1'b1);
        ld_clear = 1; step(); ld_clear = 0;
        chk("R7 cleared", ld_status, 1'b0);
        chk("R7 irq cleared", irq, 1'b0);
    endtask

    task automatic t_local_wake();
        do_reset(); enter_stop();
        cmd_wr = 1; cmd_code = 4'h0; step(); cmd_wr = 0; step(2);
        chk("R8 unarmed command ignored", clk_en, 1'b0);
        pwr_up_bit = 1; step();
        cmd_wr = 1; step(); cmd_wr = 0; step(2);
        chk("R8 set-only command ignored", clk_en, 1'b0);
        pwr_up_bit = 0; step();
        cmd_wr = 1; cmd_code = 4'h3; step(); cmd_wr = 0; step(2);
        chk("R8 wrong code ignored", clk_en, 1'b0);
        cmd_wr = 1; cmd_code = 4'h0; step(); cmd_wr = 0; step();
        chk("R8 local wake restarts", clk_en, 1'b1);
    endtask

    task automatic t_sel_clear();
        do_reset(); enter_stop();
        chk("R9 stopped first", clk_en, 1'b0);
        cfg_clk_stop_sel = 0; step(2);
        chk("R9 restarted", clk_en, 1'b1);
    endtask

    task automatic t_disable();
        do_reset();
        chk("R10 pins output", dclk_dir_in | fsync_dir_in, 1'b0);
        cfg_xcvr_disable = 1; enter_stop();
        chk("R10 dclk input", dclk_dir_in, 1'b1);
        chk("R10 fsync input", fsync_dir_in, 1'b1);
        ld_pulse = 1; step(); ld_pulse = 0; step(2);
        chk("R10 no line wake", clk_en, 1'b0);
        cfg_ld_irq_mode = 1; ld_pulse = 1; step(); ld_pulse = 0; step();
        chk("R10 no status", ld_status, 1'b0);
    endtask

    initial begin
        t_reset();
        t_no_stop();
        t_stop_waits();
        t_line_wake();
        t_irq_mode();
        t_local_wake();
        t_sel_clear();
        t_disable();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule